// File: doc/BRIEF.md
# NAND Dual-Plane Page Program Sequencer

This block drives the command, address and data bus of a NAND flash array so that pages held in a byte FIFO are programmed across several planes and several die units. One `start` pulse launches a multi-plane program. For every plane it sends a load command and five address cycles, then observes the address-to-data setup time. It then moves one page of bytes out of the FIFO, sending a byte only while the FIFO reports data. Each plane ends with a confirm command. A non-final plane is followed by a short cache-busy pause. The final plane starts the array program, which the sequencer waits out on the ready/busy line. It then reads the status byte and reports pass or fail.

A position tracker holds the current unit, page and block. Each finished program moves on to the next unit. After the last unit the page advances, and after the last page the block advances. Before the first program after reset, and whenever the block has changed, the sequencer asks an external bad-block lookup about the current block. It skips every block reported bad. All waits are cycle counters whose lengths are derived from nanosecond parameters and the clock period, rounded up.

Top module: `nand_mp_prog_seq`

## Requirements
- R1: Each plane begins with a command cycle (`nand_cle`=1, `nand_we`=1): 0x80 for plane 0 and 0x81 for every later plane. It is followed at once by exactly five address cycles (`nand_ale`=1, `nand_we`=1). `nand_cle` and `nand_ale` are never high together.
- R2: The address cycles carry, in order: column low byte 0x00, column high byte 0x00, then the row value least significant byte first. The row value is page + plane·PAGES + block·PAGES·PLANES.
- R3: After the fifth address cycle, no bus cycle occurs for ceil(T_ADL_NS/CLK_NS) cycles. When the FIFO holds data, the first data byte follows exactly that many idle cycles after the last address cycle.
- R4: A data cycle happens only in a cycle where `fifo_level` is nonzero. In that cycle `fifo_rd`=1, `nand_we`=1, `nand_cle`=`nand_ale`=0 and `nand_dq` equals `fifo_data`. Each plane takes exactly PAGE_BYTES bytes, in FIFO order.
- R5: The cycle right after a plane's last data byte is a confirm command: 0x11 for a non-final plane, 0x10 for the final plane.
- R6: After a 0x11 confirm, exactly ceil(T_DBSY_NS/CLK_NS) idle cycles pass before the next plane's 0x81.
- R7: After the 0x10 confirm, at least ceil(T_WB_NS/CLK_NS) cycles pass. The sequencer then waits for `nand_rb` high and issues command 0x70. The next cycle is a single `nand_re` strobe. The cycle after that is a one-cycle `done` pulse, with `fail` equal to bit 0 of `nand_dq_in` sampled at the strobe.
- R8: During a program, `nand_ce_n` is active low on the current unit only. Units advance 0..UNITS-1 on successive programs. After the last unit the page advances. After the last page the block advances and the unit and page return to 0.
- R9: Before the first program after reset, and after each block change, `bb_req` is held with `bb_blk` equal to the current block until `bb_ack`. A bad answer advances the block and asks again. No bus cycle occurs while `bb_req` is high.
- R10: `start` has no effect while `busy` is high. When idle, no bus cycle is issued and `busy` is 0.
- R11: During and right after reset, `nand_we`, `nand_cle`, `nand_ale`, `nand_re`, `fifo_rd`, `bb_req`, `busy` and `done` are 0, and every `nand_ce_n` bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch one multi-plane program |
| busy | output | 1 | Program in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Status fail bit, valid with `done` |
| fifo_level | input | LVL_W | Bytes available in the source FIFO |
| fifo_data | input | 8 | Byte at the FIFO head |
| fifo_rd | output | 1 | Pop the FIFO head |
| nand_ce_n | output | UNITS | Active-low unit enables |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we | output | 1 | Bus write strobe, one cycle per byte |
| nand_re | output | 1 | Status read strobe |
| nand_dq | output | 8 | Command, address or data byte |
| nand_dq_in | input | 8 | Status byte from the array |
| nand_rb | input | 1 | Ready (1) / busy (0) |
| bb_req | output | 1 | Bad-block lookup request |
| bb_blk | output | BLK_W | Block being looked up |
| bb_ack | input | 1 | Lookup answer valid |
| bb_bad | input | 1 | Looked-up block is bad |

## Verification
The sharpest coincidence is a program finishing on the last unit of the last page. In that one cycle the unit, page and block counters all roll over, and the next start must turn into a bad-block lookup before any bus cycle. The bench runs enough programs with few units and pages to hit this rollover twice, with bad blocks placed so that skips happen both at the first program and at a wrap to block 0. It judges the result by the sequence of queried blocks and by the row bytes of the following load. A second overlap is the FIFO running dry in the middle of a page: the starved-FIFO programs show that the byte count and the gating agree, so the confirm still lands right after the last byte.

// File: rtl/nmp_pkg.sv
package nmp_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_BBCHK,
      ST_LOAD,
      ST_ADDR,
      ST_ADL,
      ST_DATA,
      ST_CONF,
      ST_DBSY,
      ST_WB,
      ST_RBWAIT,
      ST_STCMD,
      ST_STRD,
      ST_FIN
   } seq_state_t;

   localparam logic [7:0] CMD_LOAD_FIRST = 8'h80;
   localparam logic [7:0] CMD_LOAD_NEXT  = 8'h81;
   localparam logic [7:0] CMD_CONF_MID   = 8'h11;
   localparam logic [7:0] CMD_CONF_LAST  = 8'h10;
   localparam logic [7:0] CMD_STATUS     = 8'h70;

   localparam int ADDR_CYCLES = 5;

   function automatic int ns_to_cyc(input int ns, input int clk_ns);
      return (ns + clk_ns - 1) / clk_ns;
   endfunction

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

   function automatic int bits_for(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/nmp_wait_timer.sv
module nmp_wait_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/nmp_position.sv
module nmp_position #(
   parameter int UNITS  = 8,
   parameter int PAGES  = 64,
   parameter int BLOCKS = 1024,
   parameter int UNIT_W = 3,
   parameter int PG_W   = 6,
   parameter int BLK_W  = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   input  logic              skip,
   input  logic              bb_clear,
   output logic [UNIT_W-1:0] unit,
   output logic [PG_W-1:0]   page,
   output logic [BLK_W-1:0]  block,
   output logic              need_bb
);

   localparam logic [UNIT_W-1:0] UNIT_LAST = UNIT_W'(UNITS - 1);
   localparam logic [PG_W-1:0]   PAGE_LAST = PG_W'(PAGES - 1);
   localparam logic [BLK_W-1:0]  BLK_LAST  = BLK_W'(BLOCKS - 1);

   logic [BLK_W-1:0] block_inc;

   assign block_inc = (block == BLK_LAST) ? '0 : block + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         unit    <= '0;
         page    <= '0;
         block   <= '0;
         need_bb <= 1'b1;
      end else begin
         if (skip) begin
            block <= block_inc;
         end else if (step) begin
            if (unit == UNIT_LAST) begin
               unit <= '0;
               if (page == PAGE_LAST) begin
                  page    <= '0;
                  block   <= block_inc;
                  need_bb <= 1'b1;
               end else begin
                  page <= page + 1'b1;
               end
            end else begin
               unit <= unit + 1'b1;
            end
         end
         if (bb_clear) begin
            need_bb <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/nmp_addr_map.sv
module nmp_addr_map #(
   parameter int UNITS  = 8,
   parameter int UNIT_W = 3,
   parameter int PG_W   = 6,
   parameter int PL_W   = 1,
   parameter int BLK_W  = 10
) (
   input  logic [2:0]        idx,
   input  logic [PL_W-1:0]   plane,
   input  logic [PG_W-1:0]   page,
   input  logic [BLK_W-1:0]  block,
   input  logic [UNIT_W-1:0] unit,
   input  logic              ce_active,
   output logic [7:0]        abyte,
   output logic [UNITS-1:0]  ce_n
);

   localparam int ROW_W = PG_W + PL_W + BLK_W;

   logic [23:0] row;

   assign row = 24'({block, plane, page});

   always_comb begin
      unique case (idx)
         3'd2:    abyte = row[7:0];
         3'd3:    abyte = row[15:8];
         3'd4:    abyte = row[23:16];
         default: abyte = 8'h00;
      endcase
   end

   if (UNITS == 1) begin : g_single_unit
      assign ce_n[0] = ~ce_active;
   end else begin : g_multi_unit
      for (genvar u = 0; u < UNITS; u++) begin : g_ce
         assign ce_n[u] = ~(ce_active && (unit == UNIT_W'(u)));
      end
   end

   if (ROW_W > 24) begin : g_row_check
      $error("row address does not fit three address cycles");
   end

endmodule

// File: rtl/nand_mp_prog_seq.sv
module nand_mp_prog_seq
   import nmp_pkg::*;
#(
   parameter int CLK_NS     = 5,
   parameter int T_ADL_NS   = 70,
   parameter int T_DBSY_NS  = 500,
   parameter int T_WB_NS    = 100,
   parameter int PAGE_BYTES = 4096,
   parameter int PLANES     = 2,
   parameter int UNITS      = 8,
   parameter int PAGES      = 64,
   parameter int BLOCKS     = 1024,
   parameter int LVL_W      = 13,
   localparam int BLK_W     = bits_for(BLOCKS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   output logic             busy,
   output logic             done,
   output logic             fail,
   input  logic [LVL_W-1:0] fifo_level,
   input  logic [7:0]       fifo_data,
   output logic             fifo_rd,
   output logic [UNITS-1:0] nand_ce_n,
   output logic             nand_cle,
   output logic             nand_ale,
   output logic             nand_we,
   output logic             nand_re,
   output logic [7:0]       nand_dq,
   input  logic [7:0]       nand_dq_in,
   input  logic             nand_rb,
   output logic             bb_req,
   output logic [BLK_W-1:0] bb_blk,
   input  logic             bb_ack,
   input  logic             bb_bad
);

   localparam int UNIT_W   = bits_for(UNITS);
   localparam int PG_W     = bits_for(PAGES);
   localparam int PL_W     = bits_for(PLANES);
   localparam int BYTE_W   = bits_for(PAGE_BYTES);
   localparam int ADL_CYC  = ns_to_cyc(T_ADL_NS, CLK_NS);
   localparam int DBSY_CYC = ns_to_cyc(T_DBSY_NS, CLK_NS);
   localparam int WB_CYC   = ns_to_cyc(T_WB_NS, CLK_NS);
   localparam int TMR_W    = $clog2(max3(ADL_CYC, DBSY_CYC, WB_CYC) + 1);

   localparam logic [BYTE_W-1:0] BYTE_LAST  = BYTE_W'(PAGE_BYTES - 1);
   localparam logic [PL_W-1:0]   PLANE_LAST = PL_W'(PLANES - 1);
   localparam logic [2:0]        ADDR_LAST  = 3'(ADDR_CYCLES - 1);

   if (CLK_NS < 1) begin : g_chk_clk
      $error("CLK_NS must be at least 1");
   end
   if (PLANES < 2) begin : g_chk_planes
      $error("PLANES must be at least 2");
   end
   if (PAGE_BYTES < 2) begin : g_chk_page
      $error("PAGE_BYTES must be at least 2");
   end
   if (ADL_CYC < 1 || DBSY_CYC < 1 || WB_CYC < 1) begin : g_chk_waits
      $error("every wait must last at least one cycle");
   end

   seq_state_t        state_q, state_d;
   logic [2:0]        aidx_q;
   logic [BYTE_W-1:0] bcnt_q;
   logic [PL_W-1:0]   plane_q;
   logic              fail_q;

   logic              tmr_load;
   logic [TMR_W-1:0]  tmr_val;
   logic              tmr_done;

   logic [UNIT_W-1:0] unit;
   logic [PG_W-1:0]   page;
   logic [BLK_W-1:0]  block;
   logic              need_bb;
   logic              pos_step, pos_skip, pos_clear;

   logic [7:0]        abyte;
   logic              ce_active;
   logic              take_byte;
   logic              last_plane;

   assign last_plane = (plane_q == PLANE_LAST);
   assign take_byte  = (state_q == ST_DATA) && (fifo_level != '0);
   assign pos_step   = (state_q == ST_FIN);
   assign pos_skip   = (state_q == ST_BBCHK) && bb_ack && bb_bad;
   assign pos_clear  = (state_q == ST_BBCHK) && bb_ack && !bb_bad;
   assign ce_active  = !(state_q inside {ST_IDLE, ST_BBCHK, ST_FIN});

   nmp_wait_timer #(
      .CNT_W(TMR_W)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_done)
   );

   nmp_position #(
      .UNITS  (UNITS),
      .PAGES  (PAGES),
      .BLOCKS (BLOCKS),
      .UNIT_W (UNIT_W),
      .PG_W   (PG_W),
      .BLK_W  (BLK_W)
   ) u_pos (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (pos_step),
      .skip     (pos_skip),
      .bb_clear (pos_clear),
      .unit     (unit),
      .page     (page),
      .block    (block),
      .need_bb  (need_bb)
   );

   nmp_addr_map #(
      .UNITS  (UNITS),
      .UNIT_W (UNIT_W),
      .PG_W   (PG_W),
      .PL_W   (PL_W),
      .BLK_W  (BLK_W)
   ) u_map (
      .idx       (aidx_q),
      .plane     (plane_q),
      .page      (page),
      .block     (block),
      .unit      (unit),
      .ce_active (ce_active),
      .abyte     (abyte),
      .ce_n      (nand_ce_n)
   );

   // next state and wait loading
   always_comb begin
      state_d  = state_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      unique case (state_q)
         ST_IDLE:   if (start) state_d = need_bb ? ST_BBCHK : ST_LOAD;
         ST_BBCHK:  if (bb_ack && !bb_bad) state_d = ST_LOAD;
         ST_LOAD:   state_d = ST_ADDR;
         ST_ADDR: begin
            if (aidx_q == ADDR_LAST) begin
               state_d  = ST_ADL;
               tmr_load = 1'b1;
               tmr_val  = TMR_W'(ADL_CYC - 1);
            end
         end
         ST_ADL:    if (tmr_done) state_d = ST_DATA;
         ST_DATA:   if (take_byte && bcnt_q == BYTE_LAST) state_d = ST_CONF;
         ST_CONF: begin
            tmr_load = 1'b1;
            if (last_plane) begin
               state_d = ST_WB;
               tmr_val = TMR_W'(WB_CYC - 1);
            end else begin
               state_d = ST_DBSY;
               tmr_val = TMR_W'(DBSY_CYC - 1);
            end
         end
         ST_DBSY:   if (tmr_done) state_d = ST_LOAD;
         ST_WB:     if (tmr_done) state_d = ST_RBWAIT;
         ST_RBWAIT: if (nand_rb) state_d = ST_STCMD;
         ST_STCMD:  state_d = ST_STRD;
         ST_STRD:   state_d = ST_FIN;
         ST_FIN:    state_d = ST_IDLE;
         default:   state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         aidx_q  <= '0;
         bcnt_q  <= '0;
         plane_q <= '0;
         fail_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         unique case (state_q)
            ST_IDLE:  plane_q <= '0;
            ST_LOAD:  aidx_q  <= '0;
            ST_ADDR:  aidx_q  <= aidx_q + 1'b1;
            ST_ADL:   bcnt_q  <= '0;
            ST_DATA:  if (take_byte) bcnt_q <= bcnt_q + 1'b1;
            ST_DBSY:  if (tmr_done) plane_q <= plane_q + 1'b1;
            ST_STRD:  fail_q  <= nand_dq_in[0];
            default:  ;
         endcase
      end
   end

   // bus drive, decoded from the present state
   always_comb begin
      nand_cle = 1'b0;
      nand_ale = 1'b0;
      nand_dq  = 8'h00;
      unique case (state_q)
         ST_LOAD: begin
            nand_cle = 1'b1;
            nand_dq  = (plane_q == '0) ? CMD_LOAD_FIRST : CMD_LOAD_NEXT;
         end
         ST_ADDR: begin
            nand_ale = 1'b1;
            nand_dq  = abyte;
         end
         ST_DATA:  nand_dq = take_byte ? fifo_data : 8'h00;
         ST_CONF: begin
            nand_cle = 1'b1;
            nand_dq  = last_plane ? CMD_CONF_LAST : CMD_CONF_MID;
         end
         ST_STCMD: begin
            nand_cle = 1'b1;
            nand_dq  = CMD_STATUS;
         end
         default: ;
      endcase
   end

   assign nand_we = nand_cle | nand_ale | take_byte;
   assign fifo_rd = take_byte;
   assign nand_re = (state_q == ST_STRD);
   assign bb_req  = (state_q == ST_BBCHK);
   assign bb_blk  = block;
   assign busy    = (state_q != ST_IDLE);
   assign done    = (state_q == ST_FIN);
   assign fail    = fail_q;

endmodule

// File: rtl/nmp_seq_checker.sv
module nmp_seq_checker #(
   parameter int LVL_W = 13,
   parameter int UNITS = 8,
   parameter int BLK_W = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             nand_cle,
   input logic             nand_ale,
   input logic             nand_we,
   input logic [7:0]       nand_dq,
   input logic             fifo_rd,
   input logic [LVL_W-1:0] fifo_level,
   input logic [UNITS-1:0] nand_ce_n,
   input logic             done,
   input logic             bb_req,
   input logic             bb_ack,
   input logic [BLK_W-1:0] bb_blk,
   input logic             nand_rb
);

   AST_CLE_ALE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(nand_cle && nand_ale)); // R1

   AST_FIFO_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_rd |-> (fifo_level != '0)); // R4

   AST_RD_IS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_rd |-> (nand_we && !nand_cle && !nand_ale)); // R4

   AST_STATUS_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (nand_we && nand_cle && nand_dq == 8'h70) |-> $past(nand_rb)); // R7

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R7

   AST_ONE_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~nand_ce_n)); // R8

   AST_BB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (bb_req && !bb_ack) |=> (bb_req && $stable(bb_blk))); // R9

   AST_BB_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      bb_req |-> !nand_we); // R9

endmodule

bind nand_mp_prog_seq nmp_seq_checker #(
   .LVL_W (LVL_W),
   .UNITS (UNITS),
   .BLK_W (BLK_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .nand_cle   (nand_cle),
   .nand_ale   (nand_ale),
   .nand_we    (nand_we),
   .nand_dq    (nand_dq),
   .fifo_rd    (fifo_rd),
   .fifo_level (fifo_level),
   .nand_ce_n  (nand_ce_n),
   .done       (done),
   .bb_req     (bb_req),
   .bb_ack     (bb_ack),
   .bb_blk     (bb_blk),
   .nand_rb    (nand_rb)
);

// File: tb/sim_nand_mp_prog_seq.sv
`timescale 1ns/1ps
module sim_nand_mp_prog_seq;

   localparam int CLK_NS     = 5;
   localparam int PAGE_BYTES = 6;
   localparam int PLANES     = 2;
   localparam int UNITS      = 2;
   localparam int PAGES      = 2;
   localparam int BLOCKS     = 4;
   localparam int LVL_W      = 8;
   localparam int BLK_W      = 2;
   localparam int ADL_CYC    = (70 + CLK_NS - 1) / CLK_NS;
   localparam int DBSY_CYC   = (500 + CLK_NS - 1) / CLK_NS;
   localparam int WB_CYC     = (100 + CLK_NS - 1) / CLK_NS;
   localparam int PROG_CYC   = 40;
   localparam int WD_LIMIT   = 100000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic busy, done, fail, fifo_rd, nand_cle, nand_ale, nand_we, nand_re, bb_req;
   logic [LVL_W-1:0] fifo_level = '0;
   logic [7:0] fifo_data = 8'h00;
   logic [UNITS-1:0] nand_ce_n;
   logic [7:0] nand_dq;
   logic [7:0] nand_dq_in = 8'h00;
   logic nand_rb = 1'b1;
   logic [BLK_W-1:0] bb_blk;
   logic bb_ack = 1'b0;
   logic bb_bad = 1'b0;

   always #2.5 clk = ~clk;

   nand_mp_prog_seq #(
      .CLK_NS(CLK_NS), .PAGE_BYTES(PAGE_BYTES), .PLANES(PLANES), .UNITS(UNITS),
      .PAGES(PAGES), .BLOCKS(BLOCKS), .LVL_W(LVL_W)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .fail(fail),
      .fifo_level(fifo_level), .fifo_data(fifo_data), .fifo_rd(fifo_rd),
      .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we(nand_we),
      .nand_re(nand_re), .nand_dq(nand_dq), .nand_dq_in(nand_dq_in), .nand_rb(nand_rb),
      .bb_req(bb_req), .bb_blk(bb_blk), .bb_ack(bb_ack), .bb_bad(bb_bad)
   );

   typedef struct packed {
      logic       cle;
      logic       ale;
      logic [7:0] dq;
      int         gap;
      logic       atl;
      int         unit;
   } ev_t;

   ev_t evq[$];
   string tagq[$];
   string gtagq[$];
   int qry[$];
   logic [7:0] fq[$];

   int total = 0, bad = 0, cyc = 0, idle = 0, done_seen = 0;
   int push_seq = 0, data_seq = 0, rb_cnt = 0;
   int exp_unit = 0, exp_page = 0, exp_block = 0;
   bit need_bb = 1, drip = 0, cur_fail = 0, re_due = 0, done_due = 0;
   bit saw_10 = 0, saw_rd = 0, start_pend = 0, timed_out = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic bit is_bad(input int b);
      return (b == 0) || (b == 2);
   endfunction

   task automatic push_ev(input bit cle, input bit ale, input logic [7:0] dq,
                          input int gap, input bit atl, input string tag, input string gtag);
      ev_t e;
      e.cle = cle; e.ale = ale; e.dq = dq; e.gap = gap; e.atl = atl; e.unit = exp_unit;
      evq.push_back(e);
      tagq.push_back(tag);
      gtagq.push_back(gtag);
   endtask

   // behavioural reference: the bus cycles one program must produce
   task automatic plan_op(input bit fl, input bit dr);
      int row;
      if (need_bb) begin
         while (is_bad(exp_block)) begin
            qry.push_back(exp_block);
            exp_block = (exp_block + 1) % BLOCKS;
         end
         qry.push_back(exp_block);
         need_bb = 0;
      end
      for (int p = 0; p < PLANES; p++) begin
         row = exp_page + p * PAGES + exp_block * PAGES * PLANES;
         push_ev(1, 0, (p == 0) ? 8'h80 : 8'h81, (p == 0) ? -1 : DBSY_CYC, 0, "R1", "R6");
         push_ev(0, 1, 8'h00, 0, 0, "R2", "R1");
         push_ev(0, 1, 8'h00, 0, 0, "R2", "R1");
         push_ev(0, 1, row[7:0], 0, 0, "R2", "R1");
         push_ev(0, 1, row[15:8], 0, 0, "R2", "R1");
         push_ev(0, 1, row[23:16], 0, 0, "R2", "R1");
         for (int b = 0; b < PAGE_BYTES; b++) begin
            push_ev(0, 0, data_seq[7:0], (b == 0) ? ADL_CYC : (dr ? -1 : 0), dr, "R4", "R3");
            data_seq++;
         end
         push_ev(1, 0, (p == PLANES - 1) ? 8'h10 : 8'h11, 0, 0, "R5", "R5");
      end
      push_ev(1, 0, 8'h70, WB_CYC, 1, "R7", "R7");
      cur_fail = fl;
      drip = dr;
      exp_unit++;
      if (exp_unit == UNITS) begin
         exp_unit = 0;
         exp_page++;
         if (exp_page == PAGES) begin
            exp_page = 0;
            exp_block = (exp_block + 1) % BLOCKS;
            need_bb = 1;
         end
      end
   endtask

   task automatic check_cycle();
      ev_t e;
      string tg, gt;
      bit re_exp, dn_exp;
      cyc++;
      re_exp = re_due; dn_exp = done_due;
      re_due = 0; done_due = 0;
      chk(nand_re == re_exp, "R7", "status read strobe", nand_re, re_exp);
      chk(done == dn_exp, "R7", "done pulse", done, dn_exp);
      if (done && dn_exp) begin
         chk(fail == cur_fail, "R7", "fail flag", fail, cur_fail);
         done_seen++;
      end
      if (re_exp) done_due = 1;
      if (nand_we) begin
         if (evq.size() == 0) begin
            chk(0, "R10", "unexpected bus cycle", {nand_cle, nand_ale, nand_dq}, 0);
         end else begin
            e = evq.pop_front(); tg = tagq.pop_front(); gt = gtagq.pop_front();
            chk(nand_cle == e.cle && nand_ale == e.ale && nand_dq == e.dq, tg,
                "bus cycle {cle,ale,dq}", {nand_cle, nand_ale, nand_dq}, {e.cle, e.ale, e.dq});
            chk(nand_ce_n == ~(UNITS'(1) << e.unit), "R8", "unit enables",
                nand_ce_n, ~(UNITS'(1) << e.unit));
            if (e.gap >= 0)
               chk(e.atl ? (idle >= e.gap) : (idle == e.gap), gt, "idle cycles before cycle",
                   idle, e.gap);
            if (!e.cle && !e.ale) chk(fifo_rd, "R4", "fifo_rd with data cycle", fifo_rd, 1);
            if (e.cle && e.dq == 8'h10) saw_10 = 1;
            if (e.cle && e.dq == 8'h70) re_due = 1;
         end
         idle = 0;
      end else begin
         idle++;
      end
      if (fifo_rd) begin
         chk(fifo_level != 0, "R4", "fifo level at read", fifo_level, 1);
         chk(nand_dq == fifo_data, "R4", "data byte from fifo", nand_dq, fifo_data);
      end
      if (bb_req) begin
         chk(!nand_we, "R9", "bus quiet during lookup", nand_we, 0);
         if (qry.size() == 0) begin
            chk(0, "R9", "unexpected lookup", bb_blk, 0);
         end else begin
            int q;
            q = qry.pop_front();
            chk(bb_blk == BLK_W'(q), "R9", "looked-up block", bb_blk, q);
         end
      end
      saw_rd = fifo_rd;
   endtask

   task automatic update_env();
      start = start_pend;
      start_pend = 0;
      if (saw_rd && fq.size() > 0) void'(fq.pop_front());
      saw_rd = 0;
      if (!drip) begin
         while (fq.size() < 4) begin fq.push_back(push_seq[7:0]); push_seq++; end
      end else if (cyc % 4 == 0 && fq.size() < 2) begin
         fq.push_back(push_seq[7:0]); push_seq++;
      end
      fifo_level = LVL_W'(fq.size());
      fifo_data = (fq.size() > 0) ? fq[0] : 8'h00;
      bb_ack = bb_req;
      bb_bad = is_bad(int'(bb_blk));
      if (saw_10) begin
         rb_cnt = PROG_CYC + 2;
         saw_10 = 0;
      end else if (rb_cnt > 0) begin
         rb_cnt--;
      end
      nand_rb = !(rb_cnt > 0 && rb_cnt <= PROG_CYC);
      nand_dq_in = {7'b0, cur_fail};
   endtask

   task automatic tick();
      @(negedge clk);
      check_cycle();
      @(posedge clk);
      #1;
      update_env();
      if (cyc > WD_LIMIT && !timed_out) begin
         timed_out = 1;
         chk(0, "R7", "watchdog: program never completed", cyc, WD_LIMIT);
      end
   endtask

   initial begin
      // R11: outputs quiet in and right after reset
      repeat (3) begin
         @(negedge clk);
         chk({nand_we, nand_cle, nand_ale, nand_re, fifo_rd, bb_req, busy, done} == 8'h00,
             "R11", "strobes in reset", {nand_we, nand_cle, nand_ale, nand_re}, 0);
         chk(nand_ce_n == '1, "R11", "unit enables in reset", nand_ce_n, '1);
      end
      @(posedge clk); #1;
      rst_n = 1'b1;
      update_env();
      repeat (4) tick();
      chk(busy == 0 && nand_ce_n == '1, "R11", "idle after reset", {busy, nand_ce_n}, 3);

      for (int op = 0; op < 10 && !timed_out; op++) begin
         int d0;
         d0 = done_seen;
         plan_op(op == 5 || op == 8, op == 3 || op == 7);
         start_pend = 1;
         if (op == 2) begin
            // R10: a second start during a program changes nothing
            repeat (30) tick();
            chk(busy == 1, "R10", "busy during program", busy, 1);
            start_pend = 1;
         end
         while (done_seen == d0 && !timed_out) tick();
         repeat (10) tick();
         chk(busy == 0, "R10", "idle after program", busy, 0);
         chk(evq.size() == 0, "R5", "bus cycles still missing", evq.size(), 0);
         chk(qry.size() == 0, "R9", "lookups still missing", qry.size(), 0);
      end
      chk(done_seen == 10, "R8", "completed programs", done_seen, 10);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule